// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural floating-point register, both the last committed value and a producer tag naming the reservation station that will write the register next. A tag of zero means the stored value is current. Instructions leave the queue in program order. For each instruction, the issue logic presents two source register indices and gets back, for each one, either a ready value or the tag of the station to wait for. In the same cycle it may record the issuing station as the new producer of a destination register.

The block also listens to the common result bus. When a station broadcasts, only the registers that still name that station take the value and drop back to "current". A register that has since been renamed to a newer producer keeps waiting for that newer producer. Overlapping writes to one register therefore settle on the last issued writer, and write-after-write and write-after-read ordering need no stalls. Source reads are combinational. A source whose producer is broadcasting in the same cycle is handed the bus value directly.

Top module: `regstat_table`

## Requirements
- R1: After reset, every register reads as ready with value 0 and tag 0.
- R2: A source register whose tag is 0 reads as ready, carrying its stored value and tag 0, in the same cycle.
- R3: A source register whose tag is nonzero and not being broadcast reads as not ready, carrying its nonzero producer tag.
- R4: When `issueValid` and `dstWrite` are high at a clock edge, register `dstIdx` holds tag `issueTag` from the next cycle on.
- R5: A broadcast with `cdbValid` high and a nonzero `cdbTag` equal to a register's tag writes `cdbValue` into that register and clears its tag at the clock edge.
- R6: A broadcast whose tag differs from a register's tag changes neither the value nor the tag of that register, and a broadcast with `cdbTag` equal to 0 writes nothing.
- R7: If a register's producer broadcasts in the same cycle as a new rename of that register, the register afterwards holds the new issuer's tag.
- R8: A source register whose tag equals a valid nonzero `cdbTag` in the current cycle reads as ready, with value `cdbValue` and tag 0.
- R9: A rename request with `issueValid` low has no effect on the table.
- R10: Source reads in a cycle reflect the table before that cycle's rename, so an instruction that reads its own destination register sees the previous producer or value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is issuing this cycle |
| dstWrite | input | 1 | The issuing instruction writes a destination register |
| dstIdx | input | IDX_W | Destination register index |
| issueTag | input | TAG_W | Station tag of the issuing instruction (nonzero) |
| srcAIdx | input | IDX_W | First source register index |
| srcBIdx | input | IDX_W | Second source register index |
| cdbValid | input | 1 | Result bus carries a broadcast |
| cdbTag | input | TAG_W | Tag of the broadcasting station |
| cdbValue | input | DATA_W | Broadcast result value |
| srcAReady | output | 1 | First source is available as a value |
| srcAValue | output | DATA_W | First source value (meaningful when ready) |
| srcATag | output | TAG_W | First source producer tag (0 when ready) |
| srcBReady | output | 1 | Second source is available as a value |
| srcBValue | output | DATA_W | Second source value (meaningful when ready) |
| srcBTag | output | TAG_W | Second source producer tag (0 when ready) |

## Verification
Source results come from combinational logic, so they are due in the same cycle as their indices and the bus inputs. The bench drives inputs just after the falling edge and compares the outputs a few nanoseconds later, well before the rising edge. Renames and bus writes take effect at the rising edge and become visible one cycle later. The bench's reference table is updated only after that edge, so each comparison is made against the pre-edge state plus the same-cycle bus forwarding.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
  // Strobes from the control to the datapath, one cycle's worth
  typedef struct packed {
    logic renameEn;  // record a new producer for the destination
    logic snoopEn;   // a usable broadcast is on the result bus
  } statStrobe_t;
endpackage

// File: rtl/regstat_ctrl.sv
module regstat_ctrl
  import regstat_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             issueValid,
  input  logic             dstWrite,
  input  logic             cdbValid,
  input  logic [TAG_W-1:0] cdbTag,
  output statStrobe_t      strb
);
  always_comb begin
    strb.renameEn = issueValid && dstWrite;
    // tag zero means "no producer"; it never names a station
    strb.snoopEn  = cdbValid && (cdbTag != '0);
  end
endmodule

// File: rtl/regstat_dp.sv
module regstat_dp
  import regstat_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  statStrobe_t                   strb,
  input  logic [IDX_W-1:0]              dstIdx,
  input  logic [TAG_W-1:0]              issueTag,
  input  logic [TAG_W-1:0]              cdbTag,
  input  logic [DATA_W-1:0]             cdbValue,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx,
  output logic [NUM_RD-1:0]             rdReady,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdValue,
  output logic [NUM_RD-1:0][TAG_W-1:0]  rdTag
);
  logic [NUM_REGS-1:0][DATA_W-1:0] valQ;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tagQ;

  // table update: newest producer wins over a retiring one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ <= '0;
      tagQ <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strb.snoopEn && (tagQ[r] == cdbTag)) begin
          valQ[r] <= cdbValue;
        end
        if (strb.renameEn && (dstIdx == IDX_W'(r))) begin
          tagQ[r] <= issueTag;
        end else if (strb.snoopEn && (tagQ[r] == cdbTag)) begin
          tagQ[r] <= '0;
        end
      end
    end
  end

  // read ports, with same-cycle forwarding from the result bus
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [TAG_W-1:0]  curTag;
    logic [DATA_W-1:0] curVal;
    always_comb begin
      curTag = tagQ[rdIdx[p]];
      curVal = valQ[rdIdx[p]];
      if (curTag == '0) begin
        rdReady[p] = 1'b1;
        rdValue[p] = curVal;
        rdTag[p]   = '0;
      end else if (strb.snoopEn && (curTag == cdbTag)) begin
        rdReady[p] = 1'b1;
        rdValue[p] = cdbValue;
        rdTag[p]   = '0;
      end else begin
        rdReady[p] = 1'b0;
        rdValue[p] = curVal;
        rdTag[p]   = curTag;
      end
    end
  end
endmodule

// File: rtl/regstat_table.sv
module regstat_table
  import regstat_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              dstWrite,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  output logic              srcAReady,
  output logic [DATA_W-1:0] srcAValue,
  output logic [TAG_W-1:0]  srcATag,
  output logic              srcBReady,
  output logic [DATA_W-1:0] srcBValue,
  output logic [TAG_W-1:0]  srcBTag
);
  statStrobe_t               strb;
  logic [1:0][IDX_W-1:0]     rdIdx;
  logic [1:0]                rdReady;
  logic [1:0][DATA_W-1:0]    rdValue;
  logic [1:0][TAG_W-1:0]     rdTag;

  assign rdIdx = {srcBIdx, srcAIdx};

  regstat_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .issueValid(issueValid),
    .dstWrite  (dstWrite),
    .cdbValid  (cdbValid),
    .cdbTag    (cdbTag),
    .strb      (strb)
  );

  regstat_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .NUM_RD(2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dstIdx  (dstIdx),
    .issueTag(issueTag),
    .cdbTag  (cdbTag),
    .cdbValue(cdbValue),
    .rdIdx   (rdIdx),
    .rdReady (rdReady),
    .rdValue (rdValue),
    .rdTag   (rdTag)
  );

  assign srcAReady = rdReady[0];
  assign srcAValue = rdValue[0];
  assign srcATag   = rdTag[0];
  assign srcBReady = rdReady[1];
  assign srcBValue = rdValue[1];
  assign srcBTag   = rdTag[1];
endmodule

// File: rtl/regstat_chk.sv
module regstat_chk #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              dstWrite,
  input logic [IDX_W-1:0]  dstIdx,
  input logic [TAG_W-1:0]  issueTag,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic              cdbValid,
  input logic [TAG_W-1:0]  cdbTag,
  input logic [DATA_W-1:0] cdbValue,
  input logic              srcAReady,
  input logic [DATA_W-1:0] srcAValue,
  input logic [TAG_W-1:0]  srcATag
);
  // R3
  pending_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcAReady |-> (srcATag != '0));

  // R4
  rename_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && dstWrite && issueTag != '0) |=>
      ((srcAIdx != $past(dstIdx)) ||
       (cdbValid && cdbTag == $past(issueTag)) ||
       (!srcAReady && srcATag == $past(issueTag))));

  // R8
  bus_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcAReady && !(issueValid && dstWrite && dstIdx == srcAIdx)) |=>
      ((srcAIdx != $past(srcAIdx)) || !cdbValid ||
       (cdbTag != $past(srcATag)) ||
       (srcAReady && srcAValue == cdbValue && srcATag == '0)));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid && !cdbValid) |=>
      ((srcAIdx != $past(srcAIdx)) || cdbValid ||
       ($stable(srcAReady) && $stable(srcAValue) && $stable(srcATag))));
endmodule

bind regstat_table regstat_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/sim_regstat_table.sv
module sim_regstat_table;
  localparam int NUM_REGS = 16;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 3;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 0, dstWrite = 0, cdbValid = 0;
  logic [IDX_W-1:0]  dstIdx = '0, srcAIdx = '0, srcBIdx = '0;
  logic [TAG_W-1:0]  issueTag = '0, cdbTag = '0;
  logic [DATA_W-1:0] cdbValue = '0;
  logic              srcAReady, srcBReady;
  logic [DATA_W-1:0] srcAValue, srcBValue;
  logic [TAG_W-1:0]  srcATag, srcBTag;

  int testCount = 0;
  int failCount = 0;

  logic [DATA_W-1:0] refVal [NUM_REGS];
  logic [TAG_W-1:0]  refTag [NUM_REGS];

  always #10 clk = ~clk;  // 50 MHz

  regstat_table #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u0 (.*);

  function automatic logic busHits(input logic [TAG_W-1:0] t);
    return cdbValid && (cdbTag != '0) && (t == cdbTag);
  endfunction

  task automatic checkPort(input string lbl, input logic [IDX_W-1:0] idx,
                           input logic rdy, input logic [DATA_W-1:0] v,
                           input logic [TAG_W-1:0] t);
    logic expRdy;
    logic [DATA_W-1:0] expVal;
    logic [TAG_W-1:0] expTag;
    string useLbl;
    if (refTag[idx] == '0) begin
      expRdy = 1; expVal = refVal[idx]; expTag = '0;
    end else if (busHits(refTag[idx])) begin
      expRdy = 1; expVal = cdbValue; expTag = '0;
    end else begin
      expRdy = 0; expVal = refVal[idx]; expTag = refTag[idx];
    end
    useLbl = lbl;
    if (useLbl == "auto")
      useLbl = (refTag[idx] == '0) ? "R2" : (expRdy ? "R8" : "R3");
    testCount++;
    if (rdy !== expRdy || t !== expTag || (expRdy && v !== expVal)) begin
      failCount++;
      $display("FAIL %s reg %0d: got rdy=%0b val=%h tag=%0d, exp rdy=%0b val=%h tag=%0d",
               useLbl, idx, rdy, v, t, expRdy, expVal, expTag);
    end
  endtask

  // one cycle: drive after falling edge, check before rising edge, update model
  task automatic step(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b,
                      input logic iv, input logic dw, input logic [IDX_W-1:0] d,
                      input logic [TAG_W-1:0] it, input logic cv,
                      input logic [TAG_W-1:0] ct, input logic [DATA_W-1:0] cval,
                      input string lbl);
    @(negedge clk);
    srcAIdx = a; srcBIdx = b; issueValid = iv; dstWrite = dw; dstIdx = d;
    issueTag = it; cdbValid = cv; cdbTag = ct; cdbValue = cval;
    #3;
    checkPort(lbl, a, srcAReady, srcAValue, srcATag);
    checkPort(lbl, b, srcBReady, srcBValue, srcBTag);
    @(posedge clk);
    for (int r = 0; r < NUM_REGS; r++) begin
      logic hit;
      hit = busHits(refTag[r]);
      if (hit) refVal[r] = cval;
      if (iv && dw && d == IDX_W'(r)) refTag[r] = it;
      else if (hit) refTag[r] = '0;
    end
  endtask

  initial begin
    #4_000_000;
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int r = 0; r < NUM_REGS; r++) begin refVal[r] = '0; refTag[r] = '0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: reset state of all registers
    for (int r = 0; r < NUM_REGS; r += 2)
      step(IDX_W'(r), IDX_W'(r+1), 0, 0, 0, 0, 0, 0, 0, "R1");

    // R10: reading own destination sees the old state; R4: rename lands next cycle
    step(3, 3, 1, 1, 3, 5, 0, 0, 0, "R10");
    step(3, 4, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R6: foreign tag and tag-zero broadcasts; R9: rename without issueValid
    step(3, 4, 0, 1, 4, 6, 1, 2, 32'hdead_beef, "R6");
    step(3, 4, 0, 0, 0, 0, 1, 0, 32'h1234_5678, "R9");
    step(3, 4, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R8: same-cycle forwarding, then R5: value committed
    step(3, 4, 0, 0, 0, 0, 1, 5, 32'h0000_aaaa, "R8");
    step(3, 4, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R7: retiring producer and new rename collide
    step(7, 7, 1, 1, 7, 1, 0, 0, 0, "R10");
    step(7, 7, 1, 1, 7, 2, 1, 1, 32'h0000_0011, "R8");
    step(7, 7, 0, 0, 0, 0, 1, 1, 32'h0000_0099, "R7");
    step(7, 7, 0, 0, 0, 0, 1, 2, 32'h0000_0022, "R8");
    step(7, 7, 0, 0, 0, 0, 0, 0, 0, "R5");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      logic [IDX_W-1:0] pick;
      logic [TAG_W-1:0] ct;
      logic [TAG_W-1:0] it;
      pick = IDX_W'($urandom_range(NUM_REGS-1));
      ct = (refTag[pick] != '0 && $urandom_range(3) != 0) ? refTag[pick]
                                                           : TAG_W'($urandom_range(7));
      it = TAG_W'($urandom_range(7, 1));
      step(IDX_W'($urandom_range(NUM_REGS-1)), IDX_W'($urandom_range(NUM_REGS-1)),
           1'($urandom_range(1)), 1'($urandom_range(1)),
           IDX_W'($urandom_range(NUM_REGS-1)), it,
           1'($urandom_range(1)), ct, $urandom, "auto");
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule